// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits on the device side of a synchronous DRAM and turns one read or write command into a stream of column addresses, one per rising clock edge. A mode-set command programs three things: how many columns a burst covers, whether the columns are visited in sequential or interleaved order, and how many clocks pass between a read beat and its data-valid strobe.

A read or write command carries a start column and a bank. The first beat is presented combinationally in the same cycle as the command, so write data can be taken with zero latency. Each following cycle presents the next column of the burst until the programmed length is used up. A full-page burst runs with no length limit and wraps around the row. A terminate command ends the burst. A new read or write ends it too, on any cycle, and starts the new burst at once. For each read beat a valid strobe leaves a shift pipeline two or three clocks later.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, with NOP commands, `beat_valid` and `rd_valid` are 0. The configuration is length 1, sequential, read latency 2.
- R2: A sequential burst of length 2, 4 or 8 counts the low log2(length) column bits upward modulo the length, starting at the start column. The upper bits stay equal to those of the start column. Length 1 presents only the start column.
- R3: An interleaved burst presents column = start XOR beat index over the low log2(length) bits. The upper bits are unchanged.
- R4: A full-page burst (length code 111, sequential) presents start + beat index modulo 1024. It keeps going until it is terminated or interrupted.
- R5: A mode-set command (cmd 100) takes `addr_col[2:0]` as the length code (000=1, 001=2, 010=4, 011=8, 111=full page), `addr_col[3]` as the type (0 sequential, 1 interleaved) and `addr_col[6:4]` as the latency (010=2, 011=3). Any other length or latency code, or full page together with interleaved, leaves the previous setting in place. A mode-set is also ignored while a burst is running or read strobes are still in flight.
- R6: Command codes are 000 NOP, 001 READ, 010 WRITE, 011 TERMINATE and 100 MODE; the other codes act as NOP. A burst of length N presents exactly N beats on consecutive cycles, the first one in the command cycle.
- R7: In the cycle of a TERMINATE command, and in every cycle after it, no beat is presented until the next read or write.
- R8: A READ or WRITE that arrives during a burst presents its own start column as a beat in that same cycle. It replaces the old burst's direction, bank and beat index.
- R9: For each read beat, `rd_valid` is high exactly L cycles later, where L is the programmed latency. Write beats raise `beat_write` in their own cycle and never produce `rd_valid`.
- R10: `beat_bank` holds the bank of the burst's command on every beat of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code (see R6) |
| addr_col | input | 10 | Start column for READ/WRITE; mode word in bits 6:0 for MODE |
| addr_bank | input | 2 | Bank of a READ/WRITE command |
| beat_valid | output | 1 | A burst beat is presented this cycle |
| beat_write | output | 1 | The current beat belongs to a write burst |
| beat_col | output | 10 | Column address of the current beat |
| beat_bank | output | 2 | Bank of the current beat |
| rd_valid | output | 1 | Read data valid, delayed by the latency |

## Verification
The bench builds the block with its default parameters: a 10-bit column, a 2-bit bank and a maximum latency of 3. With these values a full-page burst that starts at column 1022 can be driven across the 1023-to-0 wrap within a few cycles, and both latency settings can be reached. Random command streams interleave mode changes, including reserved codes, with reads, writes, terminates and interruptions on arbitrary beats. This exercises every length and type in both directions.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'b000,
        CMD_READ  = 3'b001,
        CMD_WRITE = 3'b010,
        CMD_STOP  = 3'b011,
        CMD_MODE  = 3'b100
    } cmd_e;

    // Decoded burst configuration
    typedef struct packed {
        logic [1:0] len_log;     // log2 of length for 1/2/4/8
        logic       full_page;   // unlimited sequential burst
        logic       interleave;  // interleaved ordering
        logic       lat3;        // read latency 3 (else 2)
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{len_log: 2'd0, full_page: 1'b0,
                                         interleave: 1'b0, lat3: 1'b0};

    function automatic logic mode_legal(input logic [6:0] w);
        logic len_ok;
        logic lat_ok;
        len_ok = (w[2] == 1'b0) || (w[2:0] == 3'b111 && w[3] == 1'b0);
        lat_ok = (w[6:4] == 3'b010) || (w[6:4] == 3'b011);
        return len_ok && lat_ok;
    endfunction

    function automatic burst_cfg_t mode_decode(input logic [6:0] w);
        burst_cfg_t c;
        c.len_log    = w[1:0];
        c.full_page  = (w[2:0] == 3'b111);
        c.interleave = w[3];
        c.lat3       = (w[6:4] == 3'b011);
        return c;
    endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [6:0] wdata,
    output burst_cfg_t cfg
);

    burst_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && mode_legal(wdata)) begin
            cfg_d = mode_decode(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R5
    reserved_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !mode_legal(wdata)) |=> $stable(cfg_q));

endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
    import sdram_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat_cnt,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low_mask;
    logic [COL_W-1:0] sum_col;

    always_comb begin
        low_mask = (COL_W'(1) << cfg.len_log) - COL_W'(1);
        sum_col  = start_col + beat_cnt;
        if (cfg.full_page) begin
            col = sum_col;
        end else if (cfg.interleave) begin
            col = start_col ^ (beat_cnt & low_mask);
        end else begin
            col = (start_col & ~low_mask) | (sum_col & low_mask);
        end
    end

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
    parameter int MAX_LAT = 3,
    localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_beat,
    input  logic [LAT_W-1:0] lat,
    output logic             rd_valid,
    output logic             busy
);

    logic [MAX_LAT-1:0] pipe_d, pipe_q;
    logic [LAT_W-1:0]   tap;

    always_comb begin
        pipe_d = {pipe_q[MAX_LAT-2:0], rd_beat};
        tap    = lat - LAT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rd_valid = pipe_q[tap];
    assign busy     = |pipe_q;

    // R9
    lat2_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat == LAT_W'(2) && rd_valid) |-> $past(rd_beat, 2));

    // R9
    lat3_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat == LAT_W'(3) && rd_valid) |-> $past(rd_beat, 3));

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_seq_pkg::*;
#(
    parameter int COL_W   = 10,
    parameter int BANK_W  = 2,
    parameter int MAX_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [COL_W-1:0]  addr_col,
    input  logic [BANK_W-1:0] addr_bank,
    output logic              beat_valid,
    output logic              beat_write,
    output logic [COL_W-1:0]  beat_col,
    output logic [BANK_W-1:0] beat_bank,
    output logic              rd_valid
);

    localparam int LAT_W = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic              active;
        logic              is_rd;
        logic [COL_W-1:0]  cnt;
        logic [COL_W-1:0]  start;
        logic [BANK_W-1:0] bank;
    } seq_state_t;

    seq_state_t st_d, st_q;

    burst_cfg_t        cfg;
    logic              is_rw, is_stop, mode_we, pipe_busy;
    logic [COL_W-1:0]  cur_start, cur_cnt, len_m1;
    logic [BANK_W-1:0] cur_bank;
    logic              cur_rd, last_beat;
    logic [LAT_W-1:0]  lat_sel;

    always_comb begin
        is_rw     = (cmd == CMD_READ) || (cmd == CMD_WRITE);
        is_stop   = (cmd == CMD_STOP);
        mode_we   = (cmd == CMD_MODE) && !st_q.active && !pipe_busy;

        cur_start = is_rw ? addr_col  : st_q.start;
        cur_cnt   = is_rw ? '0        : st_q.cnt;
        cur_bank  = is_rw ? addr_bank : st_q.bank;
        cur_rd    = is_rw ? (cmd == CMD_READ) : st_q.is_rd;

        beat_valid = is_rw || (st_q.active && !is_stop);
        len_m1     = (COL_W'(1) << cfg.len_log) - COL_W'(1);
        last_beat  = !cfg.full_page && (cur_cnt == len_m1);

        st_d = st_q;
        if (beat_valid) begin
            st_d.active = !last_beat;
            st_d.is_rd  = cur_rd;
            st_d.cnt    = cur_cnt + COL_W'(1);
            st_d.start  = cur_start;
            st_d.bank   = cur_bank;
        end else begin
            st_d.active = 1'b0;
        end

        beat_write = beat_valid && !cur_rd;
        beat_bank  = cur_bank;
        lat_sel    = cfg.lat3 ? LAT_W'(3) : LAT_W'(2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sdram_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode_we),
        .wdata (addr_col[6:0]),
        .cfg   (cfg)
    );

    sdram_col_gen #(.COL_W(COL_W)) u_col (
        .start_col (cur_start),
        .beat_cnt  (cur_cnt),
        .cfg       (cfg),
        .col       (beat_col)
    );

    sdram_rd_pipe #(.MAX_LAT(MAX_LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_beat  (beat_valid && cur_rd),
        .lat      (lat_sel),
        .rd_valid (rd_valid),
        .busy     (pipe_busy)
    );

    // R6
    burst_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !is_rw && !cfg.full_page) |-> (st_q.cnt <= len_m1));

    // R2
    upper_bits_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !is_rw && !cfg.full_page)
            |-> (((beat_col ^ st_q.start) & ~len_m1) == '0));

    // R7
    stop_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_stop |=> (!beat_valid || is_rw));

    // R10
    bank_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !is_rw) |-> (beat_bank == $past(beat_bank)));

endmodule

// File: tb/tb_sdram_burst_seq.sv
module tb_sdram_burst_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'b000;
    logic [9:0] addr_col = '0;
    logic [1:0] addr_bank = '0;
    logic       beat_valid, beat_write, rd_valid;
    logic [9:0] beat_col;
    logic [1:0] beat_bank;

    int n_tests = 0;
    int n_fail  = 0;
    int obs_beats = 0;

    // bench model state
    bit       m_active = 0, m_rd = 0;
    int       m_cnt = 0;
    int       m_start = 0, m_bank = 0;
    int       m_len = 0, m_il = 0, m_lat = 2;
    bit [2:0] m_pipe = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr_col(addr_col),
        .addr_bank(addr_bank), .beat_valid(beat_valid), .beat_write(beat_write),
        .beat_col(beat_col), .beat_bank(beat_bank), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_col(input int start, input int cnt, input int len, input int il);
        int mask;
        if (len == 7) return (start + cnt) % 1024;
        mask = (1 << len) - 1;
        if (il != 0) return start ^ (cnt & mask);
        return (start & ~mask) | ((start + cnt) & mask);
    endfunction

    function automatic bit legal_mode(input int w);
        int l, t, q;
        l = w & 7; t = (w >> 3) & 1; q = (w >> 4) & 7;
        return ((l < 4) || (l == 7 && t == 0)) && (q == 2 || q == 3);
    endfunction

    task automatic do_cycle(input logic [2:0] c, input int a, input int b);
        bit is_rw, e_valid, e_rd, last;
        int s, n, bk;
        string ctag;
        cmd = c; addr_col = a[9:0]; addr_bank = b[1:0];
        is_rw = (c == 3'b001) || (c == 3'b010);
        e_valid = is_rw || (m_active && c != 3'b011);
        s  = is_rw ? a : m_start;
        n  = is_rw ? 0 : m_cnt;
        bk = is_rw ? b : m_bank;
        e_rd = is_rw ? (c == 3'b001) : m_rd;
        @(negedge clk);
        chk(beat_valid == e_valid, is_rw ? "R8 beat_valid" :
            (c == 3'b011 ? "R7 beat_valid" : "R6 beat_valid"), beat_valid, e_valid);
        if (beat_valid) obs_beats++;
        if (e_valid) begin
            ctag = (m_len == 7) ? "R4 col" : (m_il != 0 ? "R3 col" : "R2 col");
            chk(beat_col == exp_col(s, n, m_len, m_il), ctag, beat_col,
                exp_col(s, n, m_len, m_il));
            chk(beat_bank == bk, "R10 bank", beat_bank, bk);
            chk(beat_write == !e_rd, "R9 beat_write", beat_write, !e_rd);
        end
        chk(rd_valid == m_pipe[m_lat-1], "R9 rd_valid", rd_valid, m_pipe[m_lat-1]);
        @(posedge clk); #1;
        // model update
        if (c == 3'b100 && !m_active && m_pipe == 0 && legal_mode(a & 127)) begin
            m_len = a & 7; m_il = (a >> 3) & 1; m_lat = (a >> 4) & 7;
        end
        m_pipe = {m_pipe[1:0], e_valid && e_rd};
        if (e_valid) begin
            last = (m_len != 7) && (n == (1 << m_len) - 1);
            m_active = !last; m_cnt = (n + 1) % 1024;
            m_start = s; m_bank = bk; m_rd = e_rd;
        end else begin
            m_active = 0;
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) do_cycle(3'b000, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(beat_valid == 0, "R1 reset beat_valid", beat_valid, 0);
        chk(rd_valid == 0, "R1 reset rd_valid", rd_valid, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        idle(2);
        // R1 default length 1, latency 2
        obs_beats = 0;
        do_cycle(3'b001, 9, 1);
        idle(4);
        chk(obs_beats == 1, "R1 default length", obs_beats, 1);

        // R2 sequential length 8 wrap from 13
        do_cycle(3'b100, 7'h23, 0);
        do_cycle(3'b001, 13, 2);
        idle(9);
        // R3 interleaved length 8 start 5 (write)
        do_cycle(3'b100, 7'h2B, 0);
        do_cycle(3'b010, 5, 3);
        idle(9);
        // R5 reserved length code rejected: keep length 4 sequential
        do_cycle(3'b100, 7'h22, 0);
        do_cycle(3'b100, 7'h25, 0);
        do_cycle(3'b100, 7'h2F, 0);
        do_cycle(3'b100, 7'h52, 0);
        obs_beats = 0;
        do_cycle(3'b001, 0, 0);
        idle(6);
        chk(obs_beats == 4, "R5 reserved codes kept length 4", obs_beats, 4);
        // R5 mode ignored while burst running
        do_cycle(3'b001, 40, 1);
        do_cycle(3'b100, 7'h20, 0);
        obs_beats = 0;
        idle(5);
        do_cycle(3'b010, 100, 0);
        idle(4);
        chk(obs_beats == 6, "R5 mode during burst ignored", obs_beats, 6);
        // R4 full page across wrap, R7 terminate
        do_cycle(3'b100, 7'h37, 0);
        do_cycle(3'b001, 1022, 2);
        idle(6);
        do_cycle(3'b011, 0, 0);
        idle(5);
        // R8 interruption on every beat
        do_cycle(3'b010, 500, 1);
        do_cycle(3'b001, 17, 3);
        do_cycle(3'b010, 1023, 0);
        do_cycle(3'b011, 0, 0);
        idle(5);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r, a;
            r = $urandom_range(0, 99);
            a = $urandom_range(0, 1023);
            if (r < 40) do_cycle(3'b000, a, 0);
            else if (r < 60) do_cycle(3'b001, a, $urandom_range(0, 3));
            else if (r < 75) do_cycle(3'b010, a, $urandom_range(0, 3));
            else if (r < 82) do_cycle(3'b011, a, 0);
            else if (r < 88) do_cycle(3'($urandom_range(5, 7)), a, 0);
            else begin
                int lc, md;
                case ($urandom_range(0, 5))
                    0: lc = 0; 1: lc = 1; 2: lc = 2; 3: lc = 3; 4: lc = 7;
                    default: lc = $urandom_range(0, 7);
                endcase
                md = lc | ($urandom_range(0, 1) << 3)
                   | (($urandom_range(0, 7) < 6 ? $urandom_range(2, 3)
                                                : $urandom_range(0, 7)) << 4);
                do_cycle(3'b100, md, 0);
                if ($urandom_range(0, 1) == 1) idle(4);
            end
        end
        idle(5);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule